// File: doc/BRIEF.md
# Interrupt Gate Dispatch Sequencer

This block receives one interrupt or exception vector at a time, together with the gate descriptor already fetched for it and the processor state it needs: the current flags, the return code selector and instruction pointer, the stack pointer and the current privilege level. It decodes the gate kind and picks one of three outcomes. The first is a procedure-style entry into a handler within the current task. The second is a request for a task switch. The third is a general protection fault.

For a procedure-style entry, the block issues its stack writes in a fixed order over a valid/ready port. It then presents the handler's code selector, entry offset, run privilege, final stack pointer and the adjusted flags for the core to load. Interrupt gates and trap gates differ only in how they treat the interrupt-enable flag. Both clear the trap flag, and both do so only after the original value has gone onto the stack. A target segment that is less privileged than the caller is never entered: the block raises a fault that carries the vector instead.

The block accepts no new vector while a dispatch is in progress. Every accepted vector ends in exactly one single-cycle outcome pulse.

Top module: `gate_dispatch`

## Requirements
- R1: The gate type code decodes as follows: 4'hE is an interrupt gate, 4'hF is a trap gate and 4'h5 is a task gate. Any other code raises `gp_fault` without any stack write.
- R2: A task gate produces one `task_req` pulse with `task_sel` equal to the gate selector. The error code and its valid flag are passed on through `task_err_code`/`task_err_valid` so they can go onto the new task's stack. The block makes no stack write of its own for a task gate.
- R3: A permitted interrupt or trap gate ends in one `entry_done` pulse, with `new_cs` equal to the gate selector and `new_eip` equal to the gate offset.
- R4: The stack writes come in this order: original flags at SP-4, return CS zero-extended to 32 bits at SP-8, return EIP at SP-12, and then the error code at SP-16 only when `err_valid` is set. `new_sp` equals the address of the last write.
- R5: A stack write that is not accepted stays valid, with address and data unchanged, until `wr_ready` is high.
- R6: `flags_out` has the trap flag (bit 8) cleared for both gate kinds, while the pushed flags image keeps its original bit 8.
- R7: For an interrupt gate, `flags_out` has the interrupt-enable flag (bit 9) cleared. For a trap gate, bit 9 is unchanged. All other bits of `flags_out` equal `cur_flags`.
- R8: When the target DPL is numerically greater than `cur_cpl`, the block makes no stack write and no entry. It raises one `gp_fault` pulse with `gp_vector` equal to the dispatched vector.
- R9: `new_cpl` equals `cur_cpl` for a conforming target and the target DPL for a non-conforming target.
- R10: `in_ready` is low and `busy` is high from acceptance until the outcome pulse. Exactly one of `entry_done`, `task_req` and `gp_fault` pulses for each accepted vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Vector and gate fields are valid |
| in_ready | output | 1 | Block can accept a vector |
| in_vector | input | 8 | Interrupt/exception vector number |
| gate_type | input | 4 | Gate type code from the descriptor |
| gate_sel | input | 16 | Gate selector (code segment or task) |
| gate_off | input | 32 | Gate offset, the handler entry point |
| tgt_dpl | input | 2 | DPL of the target code segment |
| tgt_conforming | input | 1 | Target code segment is conforming |
| cur_cpl | input | 2 | Current privilege level |
| err_valid | input | 1 | This vector carries an error code |
| err_code | input | 32 | Error code value |
| cur_flags | input | 32 | Current flags register |
| ret_cs | input | 16 | Return code selector |
| ret_eip | input | 32 | Return instruction pointer |
| cur_sp | input | 32 | Current stack pointer |
| busy | output | 1 | Dispatch in progress |
| wr_valid | output | 1 | Stack write request valid |
| wr_ready | input | 1 | Stack write accepted |
| wr_addr | output | 32 | Stack write address |
| wr_data | output | 32 | Stack write data |
| entry_done | output | 1 | Procedure entry complete (pulse) |
| flags_out | output | 32 | Flags to load on entry |
| new_cs | output | 16 | Handler code selector |
| new_eip | output | 32 | Handler entry offset |
| new_cpl | output | 2 | Privilege level the handler runs at |
| new_sp | output | 32 | Stack pointer after the pushes |
| task_req | output | 1 | Task switch request (pulse) |
| task_sel | output | 16 | Task selector from the gate |
| task_err_valid | output | 1 | Error code goes with the task switch |
| task_err_code | output | 32 | Error code for the new task's stack |
| gp_fault | output | 1 | General protection fault (pulse) |
| gp_vector | output | 8 | Vector that faulted |

## Verification
Some properties are checked by the assertions on every cycle. These are: a held stack write stays stable, at most one outcome pulses at a time, a busy block refuses vectors, the trap flag is clear at entry, task and fault outcomes never overlap a write, and an entry always follows an accepted write. Other behaviour can only be shown by the bench's directed scenarios, which compare against independently computed values. That covers the push order, the addresses and data, the selection of the interrupt-enable flag by gate kind, the privilege and conforming rules, the decoding of unknown types, and how the error code is forwarded for task gates.

// File: rtl/gd_pkg.sv
package gd_pkg;
  localparam logic [3:0] TY_INTR = 4'hE;
  localparam logic [3:0] TY_TRAP = 4'hF;
  localparam logic [3:0] TY_TASK = 4'h5;
  localparam int TF_BIT = 8;
  localparam int IF_BIT = 9;

  typedef enum logic [1:0] {K_INTR, K_TRAP, K_TASK, K_BAD} gate_kind_e;
  typedef enum logic [1:0] {O_ENTRY, O_TASK, O_FAULT} outcome_e;
  typedef enum logic [1:0] {S_IDLE, S_PUSH, S_FIN} state_e;

  function automatic gate_kind_e kind_of(input logic [3:0] t);
    case (t)
      TY_INTR: return K_INTR;
      TY_TRAP: return K_TRAP;
      TY_TASK: return K_TASK;
      default: return K_BAD;
    endcase
  endfunction

  // flags loaded at handler entry: TF always off, IF off for interrupt gates
  function automatic logic [31:0] entry_flags(input logic [31:0] f, input logic clr_if);
    logic [31:0] r;
    r = f;
    r[TF_BIT] = 1'b0;
    if (clr_if) r[IF_BIT] = 1'b0;
    return r;
  endfunction

  // address of push slot k (0-based), pre-decrement by 4 per slot
  function automatic logic [31:0] slot_addr(input logic [31:0] sp, input logic [1:0] k);
    return sp - ((32'(k) + 32'd1) << 2);
  endfunction
endpackage

// File: rtl/gd_decode.sv
module gd_decode
  import gd_pkg::*;
(
  input  logic [3:0] gate_type,
  input  logic [1:0] tgt_dpl,
  input  logic       tgt_conforming,
  input  logic [1:0] cur_cpl,
  output outcome_e   outcome,
  output logic       clr_if,
  output logic [1:0] run_cpl
);
  gate_kind_e kind;
  logic       priv_bad;

  assign kind     = kind_of(gate_type);
  assign priv_bad = (tgt_dpl > cur_cpl);
  assign clr_if   = (kind == K_INTR);
  assign run_cpl  = tgt_conforming ? cur_cpl : tgt_dpl;

  always_comb begin
    case (kind)
      K_TASK:         outcome = O_TASK;
      K_INTR, K_TRAP: outcome = priv_bad ? O_FAULT : O_ENTRY;
      default:        outcome = O_FAULT;
    endcase
  end
endmodule

// File: rtl/gd_pusher.sv
module gd_pusher
  import gd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SEL_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              active,
  input  logic              has_err,
  input  logic [31:0]       sp,
  input  logic [DATA_W-1:0] flags,
  input  logic [SEL_W-1:0]  cs,
  input  logic [DATA_W-1:0] eip,
  input  logic [DATA_W-1:0] err,
  input  logic              wr_ready,
  output logic              wr_valid,
  output logic [31:0]       wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              last_fire,
  output logic [31:0]       sp_final
);
  logic [1:0] slot;
  logic [1:0] last_slot;
  logic       fire;

  assign last_slot = has_err ? 2'd3 : 2'd2;
  assign wr_valid  = active;
  assign fire      = active && wr_ready;
  assign last_fire = fire && (slot == last_slot);
  assign wr_addr   = slot_addr(sp, slot);
  assign sp_final  = slot_addr(sp, last_slot);

  always_comb begin
    case (slot)
      2'd0:    wr_data = flags;
      2'd1:    wr_data = DATA_W'(cs);
      2'd2:    wr_data = eip;
      default: wr_data = err;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        slot <= 2'd0;
    else if (start)    slot <= 2'd0;
    else if (fire && !last_fire) slot <= slot + 2'd1;
  end
endmodule

// File: rtl/gate_dispatch.sv
module gate_dispatch
  import gd_pkg::*;
#(
  parameter int VEC_W  = 8,
  parameter int SEL_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [VEC_W-1:0]  in_vector,
  input  logic [3:0]        gate_type,
  input  logic [SEL_W-1:0]  gate_sel,
  input  logic [DATA_W-1:0] gate_off,
  input  logic [1:0]        tgt_dpl,
  input  logic              tgt_conforming,
  input  logic [1:0]        cur_cpl,
  input  logic              err_valid,
  input  logic [DATA_W-1:0] err_code,
  input  logic [DATA_W-1:0] cur_flags,
  input  logic [SEL_W-1:0]  ret_cs,
  input  logic [DATA_W-1:0] ret_eip,
  input  logic [31:0]       cur_sp,
  output logic              busy,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [31:0]       wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              entry_done,
  output logic [DATA_W-1:0] flags_out,
  output logic [SEL_W-1:0]  new_cs,
  output logic [DATA_W-1:0] new_eip,
  output logic [1:0]        new_cpl,
  output logic [31:0]       new_sp,
  output logic              task_req,
  output logic [SEL_W-1:0]  task_sel,
  output logic              task_err_valid,
  output logic [DATA_W-1:0] task_err_code,
  output logic              gp_fault,
  output logic [VEC_W-1:0]  gp_vector
);
  state_e   state;
  outcome_e dec_out, out_q;
  logic     dec_clr_if, clr_if_q;
  logic [1:0] dec_cpl, cpl_q;
  logic     accept, push_active, push_last;

  logic [VEC_W-1:0]  vec_q;
  logic [SEL_W-1:0]  sel_q, cs_q;
  logic [DATA_W-1:0] off_q, flags_q, eip_q, err_q;
  logic [31:0]       sp_q;
  logic              errv_q;

  gd_decode u_decode (
    .gate_type      (gate_type),
    .tgt_dpl        (tgt_dpl),
    .tgt_conforming (tgt_conforming),
    .cur_cpl        (cur_cpl),
    .outcome        (dec_out),
    .clr_if         (dec_clr_if),
    .run_cpl        (dec_cpl)
  );

  assign in_ready    = (state == S_IDLE);
  assign busy        = !in_ready;
  assign accept      = in_valid && in_ready;
  assign push_active = (state == S_PUSH);

  gd_pusher #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_pusher (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .active    (push_active),
    .has_err   (errv_q),
    .sp        (sp_q),
    .flags     (flags_q),
    .cs        (cs_q),
    .eip       (eip_q),
    .err       (err_q),
    .wr_ready  (wr_ready),
    .wr_valid  (wr_valid),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .last_fire (push_last),
    .sp_final  (new_sp)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      out_q <= O_ENTRY;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          out_q <= dec_out;
          state <= (dec_out == O_ENTRY) ? S_PUSH : S_FIN;
        end
        S_PUSH: if (push_last) state <= S_FIN;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= '0; sel_q <= '0; cs_q <= '0; off_q <= '0; flags_q <= '0;
      eip_q <= '0; err_q <= '0; sp_q <= '0; errv_q <= 1'b0;
      clr_if_q <= 1'b0; cpl_q <= 2'd0;
    end else if (accept) begin
      vec_q <= in_vector; sel_q <= gate_sel; cs_q <= ret_cs; off_q <= gate_off;
      flags_q <= cur_flags; eip_q <= ret_eip; err_q <= err_code; sp_q <= cur_sp;
      errv_q <= err_valid; clr_if_q <= dec_clr_if; cpl_q <= dec_cpl;
    end
  end

  assign entry_done     = (state == S_FIN) && (out_q == O_ENTRY);
  assign task_req       = (state == S_FIN) && (out_q == O_TASK);
  assign gp_fault       = (state == S_FIN) && (out_q == O_FAULT);
  assign flags_out      = entry_flags(flags_q, clr_if_q);
  assign new_cs         = sel_q;
  assign new_eip        = off_q;
  assign new_cpl        = cpl_q;
  assign task_sel       = sel_q;
  assign task_err_valid = errv_q;
  assign task_err_code  = err_q;
  assign gp_vector      = vec_q;
endmodule

// File: rtl/gate_dispatch_chk.sv
module gate_dispatch_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_ready,
  input logic        busy,
  input logic        wr_valid,
  input logic        wr_ready,
  input logic [31:0] wr_addr,
  input logic [31:0] wr_data,
  input logic        entry_done,
  input logic [31:0] flags_out,
  input logic        task_req,
  input logic        gp_fault
);
  a_r5_write_held: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  a_r10_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({entry_done, task_req, gp_fault}));

  a_r10_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready);

  a_r6_tf_clear: assert property (@(posedge clk) disable iff (!rst_n)
    entry_done |-> !flags_out[8]);

  a_r2_task_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    task_req |-> !wr_valid);

  a_r8_fault_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    gp_fault |-> !wr_valid);

  a_r3_entry_after_push: assert property (@(posedge clk) disable iff (!rst_n)
    entry_done |-> $past(wr_valid && wr_ready));
endmodule

bind gate_dispatch gate_dispatch_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_ready   (in_ready),
  .busy       (busy),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .entry_done (entry_done),
  .flags_out  (flags_out),
  .task_req   (task_req),
  .gp_fault   (gp_fault)
);

// File: tb/test_gate_dispatch.sv
module test_gate_dispatch;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        in_valid = 1'b0, in_ready;
  logic [7:0]  in_vector = '0;
  logic [3:0]  gate_type = '0;
  logic [15:0] gate_sel = '0;
  logic [31:0] gate_off = '0;
  logic [1:0]  tgt_dpl = '0, cur_cpl = '0;
  logic        tgt_conforming = 1'b0, err_valid = 1'b0;
  logic [31:0] err_code = '0, cur_flags = '0, ret_eip = '0, cur_sp = '0;
  logic [15:0] ret_cs = '0;
  logic        busy, wr_valid, wr_ready = 1'b0;
  logic [31:0] wr_addr, wr_data;
  logic        entry_done, task_req, gp_fault, task_err_valid;
  logic [31:0] flags_out, new_eip, new_sp, task_err_code;
  logic [15:0] new_cs, task_sel;
  logic [1:0]  new_cpl;
  logic [7:0]  gp_vector;

  gate_dispatch i_gate_dispatch (.*);

  int total = 0, bad = 0, cyc = 0;
  logic [31:0] wa [4];
  logic [31:0] wd [4];
  int nw;
  logic got_entry, got_task, got_fault;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      bad = bad + 1; total = total + 1;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // drive one vector, then watch until an outcome pulse; stall=1 throttles wr_ready
  task automatic dispatch(input logic [7:0] v, input logic [3:0] ty, input logic [1:0] dpl,
                          input logic conf, input logic [1:0] cpl, input logic ev,
                          input logic [31:0] fl, input logic [31:0] sp, input logic stall);
    logic pv; logic [31:0] pa, pd;
    @(negedge clk);
    in_vector = v; gate_type = ty; gate_sel = 16'h0028; gate_off = 32'hC000_1230;
    tgt_dpl = dpl; tgt_conforming = conf; cur_cpl = cpl; err_valid = ev;
    err_code = 32'h0000_5A5A; cur_flags = fl; ret_cs = 16'h001B; ret_eip = 32'h0040_1000;
    cur_sp = sp; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    nw = 0; got_entry = 0; got_task = 0; got_fault = 0; pv = 0; pa = '0; pd = '0;
    for (int k = 0; k < 40; k++) begin
      wr_ready = stall ? ((k % 3) != 2) : 1'b1;
      #1;
      chk(!in_ready && busy, "R10 busy during dispatch", {31'b0, in_ready}, 32'd0);
      if (pv && wr_valid) begin
        chk(wr_addr == pa, "R5 addr held", wr_addr, pa);
        chk(wr_data == pd, "R5 data held", wr_data, pd);
      end
      pv = wr_valid && !wr_ready; pa = wr_addr; pd = wr_data;
      if (wr_valid && wr_ready && nw < 4) begin wa[nw] = wr_addr; wd[nw] = wr_data; nw++; end
      got_entry = entry_done; got_task = task_req; got_fault = gp_fault;
      if (entry_done || task_req || gp_fault) break;
      @(negedge clk);
    end
    wr_ready = 1'b0;
  endtask

  task automatic t_reset();
    chk(in_ready && !busy, "R10 reset idle", {31'b0, in_ready}, 32'd1);
    chk(!wr_valid, "R5 reset no write", {31'b0, wr_valid}, 32'd0);
    chk(!(entry_done || task_req || gp_fault), "R10 reset no outcome", {29'b0, entry_done, task_req, gp_fault}, 32'd0);
  endtask

  task automatic check_pushes(input logic [31:0] sp, input logic [31:0] fl, input int n);
    chk(nw == n, "R4 write count", nw, n);
    if (nw >= 3) begin
      chk(wa[0] == sp - 4 && wd[0] == fl, "R4 flags push", wd[0], fl);
      chk(wd[0][8] == fl[8], "R6 pushed TF kept", wd[0], fl);
      chk(wa[1] == sp - 8 && wd[1] == 32'h0000_001B, "R4 cs push", wd[1], 32'h1B);
      chk(wa[2] == sp - 12 && wd[2] == 32'h0040_1000, "R4 eip push", wd[2], 32'h0040_1000);
    end
    if (n == 4 && nw == 4) chk(wa[3] == sp - 16 && wd[3] == 32'h5A5A, "R4 error push", wd[3], 32'h5A5A);
    chk(new_sp == sp - 32'(4 * n), "R4 new_sp", new_sp, sp - 32'(4 * n));
  endtask

  task automatic t_intr_gate();
    dispatch(8'h20, 4'hE, 2'd0, 1'b0, 2'd0, 1'b0, 32'h0000_0302, 32'h0000_1000, 1'b0);
    chk(got_entry, "R3 entry pulse", {31'b0, got_entry}, 32'd1);
    check_pushes(32'h0000_1000, 32'h0000_0302, 3);
    chk(new_cs == 16'h0028, "R3 new_cs", new_cs, 32'h28);
    chk(new_eip == 32'hC000_1230, "R3 new_eip", new_eip, 32'hC000_1230);
    chk(flags_out == 32'h0000_0002, "R7 intr clears IF and R6 TF", flags_out, 32'h2);
    chk(new_cpl == 2'd0, "R9 nonconforming cpl", new_cpl, 32'd0);
  endtask

  task automatic t_trap_err_stall();
    dispatch(8'h0D, 4'hF, 2'd0, 1'b0, 2'd3, 1'b1, 32'h0000_0346, 32'h0000_8000, 1'b1);
    chk(got_entry, "R3 trap entry", {31'b0, got_entry}, 32'd1);
    check_pushes(32'h0000_8000, 32'h0000_0346, 4);
    chk(flags_out == 32'h0000_0246, "R7 trap keeps IF and R6 TF", flags_out, 32'h246);
    chk(new_cpl == 2'd0, "R9 runs at target DPL", new_cpl, 32'd0);
  endtask

  task automatic t_conforming();
    dispatch(8'h00, 4'hE, 2'd1, 1'b1, 2'd2, 1'b0, 32'h0000_0200, 32'h0000_2000, 1'b0);
    chk(got_entry, "R9 conforming entry", {31'b0, got_entry}, 32'd1);
    chk(new_cpl == 2'd2, "R9 conforming keeps cpl", new_cpl, 32'd2);
    chk(flags_out == 32'h0, "R7 IF cleared", flags_out, 32'h0);
  endtask

  task automatic t_task_gate();
    dispatch(8'h08, 4'h5, 2'd3, 1'b0, 2'd0, 1'b1, 32'h0000_0200, 32'h0000_3000, 1'b0);
    chk(got_task && !got_entry && !got_fault, "R2 task request", {29'b0, got_entry, got_task, got_fault}, 32'd2);
    chk(task_sel == 16'h0028, "R2 task selector", task_sel, 32'h28);
    chk(task_err_valid && task_err_code == 32'h5A5A, "R2 error forwarded", task_err_code, 32'h5A5A);
    chk(nw == 0, "R2 no stack write", nw, 0);
  endtask

  task automatic t_priv_fault();
    dispatch(8'h31, 4'hE, 2'd3, 1'b0, 2'd1, 1'b0, 32'h0000_0200, 32'h0000_4000, 1'b0);
    chk(got_fault && !got_entry, "R8 fault pulse", {29'b0, got_entry, got_task, got_fault}, 32'd1);
    chk(gp_vector == 8'h31, "R8 fault vector", gp_vector, 32'h31);
    chk(nw == 0, "R8 no stack write", nw, 0);
    dispatch(8'h32, 4'hF, 2'd3, 1'b1, 2'd2, 1'b0, 32'h0000_0200, 32'h0000_4000, 1'b0);
    chk(got_fault, "R8 conforming less privileged faults", {31'b0, got_fault}, 32'd1);
  endtask

  task automatic t_bad_type();
    dispatch(8'h44, 4'h6, 2'd0, 1'b0, 2'd0, 1'b0, 32'h0000_0200, 32'h0000_5000, 1'b0);
    chk(got_fault && gp_vector == 8'h44, "R1 unknown type faults", gp_vector, 32'h44);
    chk(nw == 0, "R1 no write on unknown type", nw, 0);
    @(negedge clk);
    chk(in_ready && !busy, "R10 idle after outcome", {31'b0, in_ready}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_intr_gate();
    t_trap_err_stall();
    t_conforming();
    t_task_gate();
    t_priv_fault();
    t_bad_type();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule